// File: doc/BRIEF.md
# HDLC Transmit Underrun Frame Closer

This block ends an HDLC transmit frame cleanly when the transmit queue runs dry, whether because the data ran out (underrun) or because the message is complete. It owns the transmit-underrun status latch (TXUE). It also owns a small serial sequencer that emits a frame trailer followed by a closing flag. The trailer is either the 16-bit CRC supplied by an external generator or an abort run of ones, chosen by a configuration bit. Bit stuffing and the CRC arithmetic are handled elsewhere.

The trailer goes out only when the latch makes a fresh 0-to-1 move at the frame end. If software has left TXUE set from an earlier event, the frame is closed with the flag alone. So software clears the latch with a reset command before each frame whose trailer it wants. That clear, the 1-to-0 edge of TXUE, is what raises the status interrupt. The disable-transmit and send-abort commands also set the latch, but they start no transmission themselves.

Top module: `txue_frame_closer`

## Requirements
- R1: After reset the serial output is 1, busy is 0, TXUE is 0 and the interrupt is 0.
- R2: While idle, `queue_empty` and `frame_active` both high in one cycle start a close sequence. From the next cycle, busy reads 1 and TXUE reads 1.
- R3: With TXUE 0 at the start and `cfg_abort_sel` 0, the output carries the 16 bits of `crc_val` least significant bit first. After them it carries the closing flag.
- R4: With TXUE 0 at the start and `cfg_abort_sel` 1, the output carries eight 1 bits and then the closing flag.
- R5: With TXUE already 1 at the start, no trailer is sent, only the closing flag. The flag is 0x7E sent least significant bit first, so a 0, then six 1 bits, then a 0.
- R6: The first bit appears in the cycle after the start. Each later bit appears in the cycle after a `bit_stb` pulse. The output holds steady between strobes.
- R7: In the cycle after the strobe that retires the last flag bit, busy is 0 and the output is 1.
- R8: A `cmd_tx_off` or `cmd_send_abort` pulse sets TXUE and starts no transmission: busy stays 0 and the output stays 1.
- R9: A `cmd_clr_ue` pulse while TXUE is 1 clears it. The interrupt is high for exactly the one cycle in which TXUE first reads 0.
- R10: A `cmd_clr_ue` pulse while TXUE is 0 raises no interrupt.
- R11: When a set cause and `cmd_clr_ue` fall in the same cycle, the set wins. TXUE reads 1 afterwards and no interrupt is raised.
- R12: While busy, a new start condition is ignored. `crc_val` and `cfg_abort_sel` are captured at the start, and later changes do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One pulse per serial bit time |
| queue_empty | input | 1 | Transmit queue holds no data |
| frame_active | input | 1 | A frame is in progress or just ended |
| cfg_abort_sel | input | 1 | Trailer choice: 0 sends CRC, 1 sends abort ones |
| crc_val | input | 16 | CRC value from the external generator |
| cmd_clr_ue | input | 1 | Reset-underrun-latch command pulse |
| cmd_tx_off | input | 1 | Disable-transmit command pulse |
| cmd_send_abort | input | 1 | Send-abort command pulse |
| ser_out | output | 1 | Serial bit output, 1 when idle |
| busy | output | 1 | Close sequence in progress |
| txue | output | 1 | Underrun/end-of-message status latch |
| irq | output | 1 | Status interrupt on the 1-to-0 edge of TXUE |

## Verification
Two functions can collide in one cycle. A frame-end start can set TXUE in the same cycle that software issues the clear command, and a disable-transmit or send-abort pulse can do the same. The bench drives these collisions deliberately, with TXUE both 0 and 1 beforehand. It then expects TXUE to read 1, no interrupt pulse, and a trailer choice made from the latch value held before the collision. Every frame also repeats a start condition partway through its sequence and changes the CRC and configuration inputs. The bench checks that the bits sent still match the values captured at the start.

// File: rtl/closer_pkg.sv
package closer_pkg;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_TRAILER = 2'd1,
        PH_FLAG    = 2'd2
    } phase_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/txue_status_latch.sv
module txue_status_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic txue_o,
    output logic irq_o
);

    typedef struct packed {
        logic txue;
        logic irq;
    } latch_t;

    latch_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (set_i)
            st_d.txue = 1'b1;
        else if (clr_i)
            st_d.txue = 1'b0;
        st_d.irq = st_q.txue & ~st_d.txue;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign txue_o = st_q.txue;
    assign irq_o  = st_q.irq;

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> txue_o);
    assert_clear_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !txue_o);
    assert_irq_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(txue_o) |-> irq_o);
    assert_irq_needs_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (!txue_o && $past(txue_o)));

endmodule

// File: rtl/closer_sequencer.sv
module closer_sequencer
    import closer_pkg::*;
#(
    parameter int unsigned CRC_W    = 16,
    parameter int unsigned ABORT_W  = 8,
    parameter int unsigned FLAG_W   = 8,
    parameter logic [FLAG_W-1:0] FLAG_PAT = 8'h7E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             trailer_en_i,
    input  logic             abort_sel_i,
    input  logic [CRC_W-1:0] crc_i,
    input  logic             bit_stb_i,
    output logic             ser_o,
    output logic             busy_o,
    output phase_e           phase_o
);

    localparam int unsigned SH_W  = max_u(max_u(CRC_W, ABORT_W), FLAG_W);
    localparam int unsigned CNT_W = $clog2(SH_W + 1);

    typedef struct packed {
        phase_e             ph;
        logic [SH_W-1:0]    sh;
        logic [CNT_W-1:0]   left;
    } seq_t;

    seq_t q, d;

    logic [SH_W-1:0] abort_fill;
    logic [SH_W-1:0] flag_fill;
    logic [SH_W-1:0] crc_fill;

    for (genvar g = 0; g < SH_W; g++) begin : g_fill
        assign abort_fill[g] = (g < ABORT_W);
        if (g < FLAG_W) begin : g_flag
            assign flag_fill[g] = FLAG_PAT[g];
        end else begin : g_flag_pad
            assign flag_fill[g] = 1'b0;
        end
        if (g < CRC_W) begin : g_crc
            assign crc_fill[g] = crc_i[g];
        end else begin : g_crc_pad
            assign crc_fill[g] = 1'b0;
        end
    end

    always_comb begin
        d = q;
        unique case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    if (trailer_en_i) begin
                        d.ph   = PH_TRAILER;
                        d.sh   = abort_sel_i ? abort_fill : crc_fill;
                        d.left = abort_sel_i ? CNT_W'(ABORT_W) : CNT_W'(CRC_W);
                    end else begin
                        d.ph   = PH_FLAG;
                        d.sh   = flag_fill;
                        d.left = CNT_W'(FLAG_W);
                    end
                end
            end
            PH_TRAILER, PH_FLAG: begin
                if (bit_stb_i) begin
                    if (q.left == CNT_W'(1)) begin
                        if (q.ph == PH_TRAILER) begin
                            d.ph   = PH_FLAG;
                            d.sh   = flag_fill;
                            d.left = CNT_W'(FLAG_W);
                        end else begin
                            d.ph   = PH_IDLE;
                            d.sh   = '0;
                            d.left = '0;
                        end
                    end else begin
                        d.sh   = q.sh >> 1;
                        d.left = q.left - CNT_W'(1);
                    end
                end
            end
            default: begin
                d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ph   <= PH_IDLE;
            q.sh   <= '0;
            q.left <= '0;
        end else begin
            q <= d;
        end
    end

    assign ser_o   = (q.ph == PH_IDLE) ? 1'b1 : q.sh[0];
    assign busy_o  = (q.ph != PH_IDLE);
    assign phase_o = q.ph;

    assert_idle_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> ser_o);
    assert_hold_between_strobes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !bit_stb_i) |=> $stable(ser_o));
    assert_flag_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_FLAG && q.left == CNT_W'(1) && bit_stb_i) |=> !busy_o);
    assert_trailer_to_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ph == PH_TRAILER && q.left == CNT_W'(1) && bit_stb_i) |=> (phase_o == PH_FLAG));

endmodule

// File: rtl/txue_frame_closer.sv
module txue_frame_closer
    import closer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_stb,
    input  logic        queue_empty,
    input  logic        frame_active,
    input  logic        cfg_abort_sel,
    input  logic [15:0] crc_val,
    input  logic        cmd_clr_ue,
    input  logic        cmd_tx_off,
    input  logic        cmd_send_abort,
    output logic        ser_out,
    output logic        busy,
    output logic        txue,
    output logic        irq
);

    logic   close_start;
    logic   set_cause;
    phase_e phase;

    assign close_start = !busy && queue_empty && frame_active;
    assign set_cause   = close_start | cmd_tx_off | cmd_send_abort;

    txue_status_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_cause),
        .clr_i  (cmd_clr_ue),
        .txue_o (txue),
        .irq_o  (irq)
    );

    closer_sequencer #(
        .CRC_W    (16),
        .ABORT_W  (8),
        .FLAG_W   (8),
        .FLAG_PAT (8'h7E)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (close_start),
        .trailer_en_i (!txue),
        .abort_sel_i  (cfg_abort_sel),
        .crc_i        (crc_val),
        .bit_stb_i    (bit_stb),
        .ser_o        (ser_out),
        .busy_o       (busy),
        .phase_o      (phase)
    );

    assert_fresh_edge_trailer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (close_start && !txue) |=> (phase == PH_TRAILER));
    assert_latched_flag_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (close_start && txue) |=> (phase == PH_FLAG));
    assert_start_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        close_start |=> (busy && txue));
    assert_cmd_no_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !close_start && (cmd_tx_off || cmd_send_abort)) |=> !busy);

endmodule

// File: tb/sim_txue_frame_closer.sv
module sim_txue_frame_closer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_stb = 1'b0;
    logic        queue_empty = 1'b0;
    logic        frame_active = 1'b0;
    logic        cfg_abort_sel = 1'b0;
    logic [15:0] crc_val = '0;
    logic        cmd_clr_ue = 1'b0;
    logic        cmd_tx_off = 1'b0;
    logic        cmd_send_abort = 1'b0;
    logic        ser_out, busy, txue, irq;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    txue_frame_closer u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .queue_empty(queue_empty),
        .frame_active(frame_active), .cfg_abort_sel(cfg_abort_sel), .crc_val(crc_val),
        .cmd_clr_ue(cmd_clr_ue), .cmd_tx_off(cmd_tx_off), .cmd_send_abort(cmd_send_abort),
        .ser_out(ser_out), .busy(busy), .txue(txue), .irq(irq)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nedge();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic set_latch(input bit val);
        if (val) cmd_tx_off = 1'b1; else cmd_clr_ue = 1'b1;
        nedge();
        cmd_tx_off = 1'b0;
        cmd_clr_ue = 1'b0;
        nedge();
        nedge();
    endtask

    // one frame close: trailer choice, pre-latched state, strobe spacing
    task automatic run_frame(input bit cfg, input logic [15:0] crc, input bit pre, input int gap);
        logic exp_bits [0:31];
        int   n = 0;
        int   n_tr;
        logic [7:0] flag = 8'h7E;
        set_latch(pre);
        chk(32'(txue), 32'(pre), "R8 R9 latch preset");
        if (!pre) begin
            if (cfg) begin
                for (int k = 0; k < 8; k++) begin exp_bits[n] = 1'b1; n++; end
            end else begin
                for (int k = 0; k < 16; k++) begin exp_bits[n] = crc[k]; n++; end
            end
        end
        n_tr = n;
        for (int k = 0; k < 8; k++) begin exp_bits[n] = flag[k]; n++; end

        cfg_abort_sel = cfg;
        crc_val = crc;
        queue_empty = 1'b1;
        frame_active = 1'b1;
        nedge();
        chk(32'(busy), 32'd1, "R2 busy after start");
        chk(32'(txue), 32'd1, "R2 txue after start");
        queue_empty = 1'b0;
        frame_active = 1'b0;
        cfg_abort_sel = ~cfg;   // R12: late changes must not matter
        crc_val = ~crc;
        for (int i = 0; i < n; i++) begin
            string tag;
            if (i < n_tr) tag = cfg ? "R4 abort bit" : "R3 crc bit";
            else          tag = pre ? "R5 flag only" : "R3 closing flag";
            chk(32'(ser_out), 32'(exp_bits[i]), tag);
            for (int g = 1; g < gap; g++) begin
                nedge();
                chk(32'(ser_out), 32'(exp_bits[i]), "R6 hold between strobes");
            end
            bit_stb = 1'b1;
            if (i == 2) begin
                queue_empty = 1'b1;   // R12: restart ignored while busy
                frame_active = 1'b1;
            end
            nedge();
            bit_stb = 1'b0;
            queue_empty = 1'b0;
            frame_active = 1'b0;
        end
        chk(32'(busy), 32'd0, "R7 idle after flag");
        chk(32'(ser_out), 32'd1, "R7 mark after flag");
        nedge();
        chk(32'(busy), 32'd0, "R12 no restart");
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] crcs [0:3];
        crcs[0] = 16'h0000; crcs[1] = 16'hFFFF; crcs[2] = 16'hA5C3; crcs[3] = 16'h8001;
        nedge(); nedge();
        chk(32'(ser_out), 32'd1, "R1 ser reset");
        chk(32'(busy), 32'd0, "R1 busy reset");
        chk(32'(txue), 32'd0, "R1 txue reset");
        chk(32'(irq), 32'd0, "R1 irq reset");
        rst_n = 1'b1;
        nedge();

        // R8: commands set the latch without transmitting
        for (int c = 0; c < 2; c++) begin
            set_latch(1'b0);
            if (c == 0) cmd_tx_off = 1'b1; else cmd_send_abort = 1'b1;
            nedge();
            cmd_tx_off = 1'b0;
            cmd_send_abort = 1'b0;
            chk(32'(txue), 32'd1, "R8 command sets txue");
            chk(32'(busy), 32'd0, "R8 no busy");
            chk(32'(ser_out), 32'd1, "R8 line mark");
            nedge();
            chk(32'(busy), 32'd0, "R8 still idle");
        end

        // R9: clear from 1 gives one-cycle irq
        set_latch(1'b1);
        cmd_clr_ue = 1'b1;
        nedge();
        cmd_clr_ue = 1'b0;
        chk(32'(txue), 32'd0, "R9 cleared");
        chk(32'(irq), 32'd1, "R9 irq pulse");
        nedge();
        chk(32'(irq), 32'd0, "R9 irq one cycle");

        // R10: clear from 0 gives nothing
        cmd_clr_ue = 1'b1;
        nedge();
        cmd_clr_ue = 1'b0;
        chk(32'(txue), 32'd0, "R10 stays clear");
        chk(32'(irq), 32'd0, "R10 no irq");

        // R11: collisions, both prior latch values, each set cause
        for (int pre = 0; pre < 2; pre++) begin
            for (int c = 0; c < 3; c++) begin
                set_latch(pre[0]);
                cmd_clr_ue = 1'b1;
                if (c == 0) cmd_tx_off = 1'b1;
                else if (c == 1) cmd_send_abort = 1'b1;
                else begin queue_empty = 1'b1; frame_active = 1'b1; cfg_abort_sel = 1'b1; end
                nedge();
                cmd_clr_ue = 1'b0; cmd_tx_off = 1'b0; cmd_send_abort = 1'b0;
                queue_empty = 1'b0; frame_active = 1'b0;
                chk(32'(txue), 32'd1, "R11 set wins");
                chk(32'(irq), 32'd0, "R11 no irq");
                if (c == 2) begin
                    // trailer decided by the latch value before the collision
                    int len = pre ? 8 : 16;
                    for (int i = 0; i < len; i++) begin
                        logic e;
                        if (pre) e = (i != 0 && i != 7);
                        else     e = (i < 8) ? 1'b1 : (i != 8 && i != 15);
                        chk(32'(ser_out), 32'(e), pre ? "R11 R5 flag only" : "R11 R4 abort trailer");
                        bit_stb = 1'b1;
                        nedge();
                        bit_stb = 1'b0;
                    end
                    chk(32'(busy), 32'd0, "R11 R7 idle");
                end
                nedge();
            end
        end

        // main sweep
        for (int cfg = 0; cfg < 2; cfg++)
            for (int pre = 0; pre < 2; pre++)
                for (int gap = 1; gap <= 3; gap++)
                    for (int k = 0; k < 4; k++)
                        run_frame(cfg[0], crcs[k], pre[0], gap);

        summary();
        $finish;
    end

endmodule